// File: doc/BRIEF.md
# Segment ID scrambler

This block turns a 36-bit proto segment identifier into a scattered virtual segment identifier. It multiplies by the fixed prime 200730139 and reduces the product modulo 2^36 − 1. The modulus has the form 2^n − 1, so no divider is needed. The 64-bit product is split at bit 36 and the two parts are added. One end-around carry correction then brings the sum into range. The multiplier is co-prime to the modulus, so the mapping is one-to-one over all inputs below the modulus.

The proto identifier is built at the input from one of two sources, picked by a mode bit:
- Kernel mode: the full effective segment ID is used unchanged.
- User mode: a 19-bit context is shifted up by 16 and combined with the low 16 bits of the segment ID.

The all-ones 36-bit value is reserved and never appears as a result. A proto value equal to all-ones is flagged alongside its result. The datapath is a three-register pipeline with a valid bit. It accepts one request per cycle.

Top module: `sid_scrambler`

## Requirements
- R1: For a valid request whose proto value P is below 2^36 − 1, the result equals (P × 200730139) mod (2^36 − 1).
- R2: When `in_user` is 1, P = {1'b0, in_ctx[18:0], in_seg[15:0]}. Bits 35:16 of `in_seg` have no effect on the result.
- R3: When `in_user` is 0, P = in_seg[35:0]. `in_ctx` has no effect on the result.
- R4: A valid result is never 36'hF_FFFF_FFFF. A proto value of 0 gives 0, and a proto value of 1 gives 200730139.
- R5: `out_err` is 1 on a valid result exactly when P was 36'hF_FFFF_FFFF. The result for that P is 0.
- R6: `out_valid` repeats `in_valid` three rising clock edges later. Back-to-back requests give back-to-back results in the same order.
- R7: While `rst_n` is low, `out_valid` and `out_err` are 0 and `out_vsid` is 0. A reset asserted mid-stream discards every request in flight.
- R8: Products whose folded sum reaches or passes the modulus are fixed by the end-around carry. For example, P = 2^36 − 2 gives 68518746596.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_user | input | 1 | 1 selects user proto formation, 0 selects kernel |
| in_ctx | input | 19 | User context number |
| in_seg | input | 36 | Effective segment ID |
| out_valid | output | 1 | Result present this cycle |
| out_vsid | output | 36 | Scrambled segment identifier |
| out_err | output | 1 | Result came from the reserved all-ones proto value |

## Verification
The bench builds the block with `MUL_SPLIT` = 1, so the product is formed as two partial products whose sum must reproduce the full 64-bit multiply. All width parameters keep their default values. This puts the real 36-bit modulus, the 28-bit multiplier and the 19/16-bit user split within reach. At those sizes the largest fold sums occur, where the end-around carry decides the answer, and the reserved all-ones proto can be driven directly.

// File: rtl/sid_pkg.sv
package sid_pkg;

   typedef enum logic {
      SID_MODE_KERNEL = 1'b0,
      SID_MODE_USER   = 1'b1
   } sid_mode_e;

endpackage

// File: rtl/sid_proto_form.sv
module sid_proto_form
   import sid_pkg::*;
#(
   parameter int unsigned SID_W  = 36,
   parameter int unsigned CTX_W  = 19,
   parameter int unsigned USEG_W = 16
) (
   input  logic              mode_i,
   input  logic [CTX_W-1:0]  ctx_i,
   input  logic [SID_W-1:0]  seg_i,
   output logic [SID_W-1:0]  proto_o,
   output logic              reserved_o
);

   sid_mode_e mode;

   always_comb begin
      mode = sid_mode_e'(mode_i);
      case (mode)
         SID_MODE_USER: proto_o = SID_W'({ctx_i, seg_i[USEG_W-1:0]});
         default:       proto_o = seg_i;
      endcase
      reserved_o = &proto_o;
   end

endmodule

// File: rtl/sid_mul_stage.sv
module sid_mul_stage #(
   parameter int unsigned SID_W     = 36,
   parameter int unsigned MULT_W    = 28,
   parameter logic [MULT_W-1:0] MULT = 28'd200730139,
   parameter bit          MUL_SPLIT = 1'b0,
   localparam int unsigned PROD_W   = SID_W + MULT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_i,
   input  logic [SID_W-1:0]  proto_i,
   input  logic              err_i,
   output logic              v_o,
   output logic [PROD_W-1:0] prod_o,
   output logic              err_o
);

   logic [PROD_W-1:0] prod_c;

   generate
      if (MUL_SPLIT) begin : g_split
         localparam int unsigned LO_W = MULT_W / 2;
         logic [PROD_W-1:0] pp_lo;
         logic [PROD_W-1:0] pp_hi;
         assign pp_lo  = PROD_W'(proto_i) * PROD_W'(MULT[LO_W-1:0]);
         assign pp_hi  = (PROD_W'(proto_i) * PROD_W'(MULT[MULT_W-1:LO_W])) << LO_W;
         assign prod_c = pp_lo + pp_hi;
      end else begin : g_direct
         assign prod_c = PROD_W'(proto_i) * PROD_W'(MULT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         prod_o <= '0;
         err_o  <= 1'b0;
      end else begin
         v_o    <= v_i;
         prod_o <= prod_c;
         err_o  <= v_i & err_i;
      end
   end

endmodule

// File: rtl/sid_fold_stage.sv
module sid_fold_stage #(
   parameter int unsigned SID_W  = 36,
   parameter int unsigned MULT_W = 28,
   localparam int unsigned PROD_W = SID_W + MULT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_i,
   input  logic [PROD_W-1:0] prod_i,
   input  logic              err_i,
   output logic              v_o,
   output logic [SID_W:0]    x_o,
   output logic              err_o
);

   localparam logic [SID_W:0] X_MAX =
      {1'b0, {SID_W{1'b1}}} + {{(SID_W+1-MULT_W){1'b0}}, {MULT_W{1'b1}}};

   logic [SID_W:0] x_c;

   assign x_c = {1'b0, prod_i[SID_W-1:0]}
              + {{(SID_W+1-MULT_W){1'b0}}, prod_i[PROD_W-1:SID_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         x_o   <= '0;
         err_o <= 1'b0;
      end else begin
         v_o   <= v_i;
         x_o   <= x_c;
         err_o <= v_i & err_i;
      end
   end

   // R8: the folded sum stays below one modulus plus the multiplier range
   a_r8_fold_bound: assert property (@(posedge clk) disable iff (!rst_n)
      v_o |-> (x_o <= X_MAX));

endmodule

// File: rtl/sid_correct_stage.sv
module sid_correct_stage #(
   parameter int unsigned SID_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic [SID_W:0]   x_i,
   input  logic             err_i,
   output logic             v_o,
   output logic [SID_W-1:0] vsid_o,
   output logic             err_o
);

   logic             wrap;
   logic [SID_W-1:0] vsid_c;

   // x + 1 carries into bit SID_W exactly when x reaches the modulus
   assign wrap   = x_i[SID_W] | (&x_i[SID_W-1:0]);
   assign vsid_c = x_i[SID_W-1:0] + SID_W'(wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         vsid_o <= '0;
         err_o  <= 1'b0;
      end else begin
         v_o    <= v_i;
         vsid_o <= vsid_c;
         err_o  <= v_i & err_i;
      end
   end

   // R4: the reserved code never leaves the block
   a_r4_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      v_o |-> (vsid_o != {SID_W{1'b1}}));

endmodule

// File: rtl/sid_scrambler.sv
module sid_scrambler #(
   parameter int unsigned SID_W     = 36,
   parameter int unsigned MULT_W    = 28,
   parameter logic [MULT_W-1:0] MULT = 28'd200730139,
   parameter int unsigned CTX_W     = 19,
   parameter int unsigned USEG_W    = 16,
   parameter bit          MUL_SPLIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_user,
   input  logic [CTX_W-1:0]  in_ctx,
   input  logic [SID_W-1:0]  in_seg,
   output logic              out_valid,
   output logic [SID_W-1:0]  out_vsid,
   output logic              out_err
);

   localparam int unsigned PROD_W = SID_W + MULT_W;

   generate
      if (MULT_W > SID_W) begin : g_bad_mult_w
         $error("sid_scrambler: MULT_W must not exceed SID_W");
      end
      if (CTX_W + USEG_W >= SID_W) begin : g_bad_user_split
         $error("sid_scrambler: user proto must leave the top bit clear");
      end
      if (MULT == '0) begin : g_bad_mult
         $error("sid_scrambler: multiplier must be nonzero");
      end
      if (MULT_W < 2) begin : g_bad_mult_small
         $error("sid_scrambler: MULT_W must be at least 2");
      end
   endgenerate

   logic [SID_W-1:0]  proto;
   logic              reserved;
   logic              s1_v, s1_err;
   logic [PROD_W-1:0] s1_prod;
   logic              s2_v, s2_err;
   logic [SID_W:0]    s2_x;

   sid_proto_form #(
      .SID_W (SID_W),
      .CTX_W (CTX_W),
      .USEG_W(USEG_W)
   ) i_form (
      .mode_i    (in_user),
      .ctx_i     (in_ctx),
      .seg_i     (in_seg),
      .proto_o   (proto),
      .reserved_o(reserved)
   );

   sid_mul_stage #(
      .SID_W    (SID_W),
      .MULT_W   (MULT_W),
      .MULT     (MULT),
      .MUL_SPLIT(MUL_SPLIT)
   ) i_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_i    (in_valid),
      .proto_i(proto),
      .err_i  (reserved),
      .v_o    (s1_v),
      .prod_o (s1_prod),
      .err_o  (s1_err)
   );

   sid_fold_stage #(
      .SID_W (SID_W),
      .MULT_W(MULT_W)
   ) i_fold (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (s1_v),
      .prod_i(s1_prod),
      .err_i (s1_err),
      .v_o   (s2_v),
      .x_o   (s2_x),
      .err_o (s2_err)
   );

   sid_correct_stage #(
      .SID_W(SID_W)
   ) i_corr (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (s2_v),
      .x_i   (s2_x),
      .err_i (s2_err),
      .v_o   (out_valid),
      .vsid_o(out_vsid),
      .err_o (out_err)
   );

   // R6: valid advances one stage per edge
   a_r6_valid_fold: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v == $past(in_valid) || $past(!rst_n) || !$past(rst_n, 1));
   a_r6_valid_out: assert property (@(posedge clk) disable iff (!rst_n)
      s2_v |=> out_valid);
   a_r6_bubble_out: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_v |=> !out_valid);

   // R5: the reserved proto value leaves as a flagged zero
   a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_vsid == '0));

   // R5: the error flag only travels with a valid result
   a_r5_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);

endmodule

// File: tb/test_sid_scrambler.sv
module test_sid_scrambler;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYCLES = 20000;
   localparam int N_VEC = 10;
   localparam logic [63:0] MOD64 = 64'h0000_000F_FFFF_FFFF;

   // each entry: {user, ctx[18:0], seg[35:0]}
   localparam logic [55:0] VEC [N_VEC] = '{
      {1'b0, 19'h00000, 36'h0_0000_0000},
      {1'b0, 19'h00000, 36'h0_0000_0001},
      {1'b0, 19'h00000, 36'hF_FFFF_FFFE},
      {1'b0, 19'h00000, 36'hF_FFFF_FFFF},
      {1'b0, 19'h00000, 36'hC_0000_0000},
      {1'b1, 19'h7FFFF, 36'h0_0000_FFFF},
      {1'b1, 19'h00000, 36'h0_0000_0001},
      {1'b1, 19'h00001, 36'h0_0000_0000},
      {1'b1, 19'h12345, 36'hA_BCDE_1234},
      {1'b0, 19'h55555, 36'h1_2345_6789}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_user;
   logic [18:0] in_ctx;
   logic [35:0] in_seg;
   logic        out_valid;
   logic [35:0] out_vsid;
   logic        out_err;

   int errors = 0;
   int checks = 0;

   logic        exp_v [3];
   logic [35:0] exp_d [3];
   logic        exp_e [3];
   string       exp_t [3];

   sid_scrambler #(.MUL_SPLIT(1'b1)) i_sid_scrambler (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_user  (in_user),
      .in_ctx   (in_ctx),
      .in_seg   (in_seg),
      .out_valid(out_valid),
      .out_vsid (out_vsid),
      .out_err  (out_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [35:0] proto_of(logic u, logic [18:0] c, logic [35:0] s);
      return u ? {1'b0, c, s[15:0]} : s;
   endfunction

   function automatic logic [35:0] ref_vsid(logic [35:0] p);
      logic [63:0] prod;
      prod = {28'b0, p} * 64'd200730139;
      return 36'(prod % MOD64);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_pipe();
      for (int k = 0; k < 3; k++) begin
         exp_v[k] = 1'b0; exp_d[k] = '0; exp_e[k] = 1'b0; exp_t[k] = "idle";
      end
   endtask

   // called at a negedge: checks the result of the request driven three steps ago
   task automatic step(logic v, logic u, logic [18:0] c, logic [35:0] s, string tag);
      logic [35:0] p;
      check({exp_t[2], " R6 valid"}, 64'(out_valid), 64'(exp_v[2]));
      if (exp_v[2]) begin
         check({exp_t[2], " vsid"}, 64'(out_vsid), 64'(exp_d[2]));
         check({exp_t[2], " R5 err"}, 64'(out_err), 64'(exp_e[2]));
      end
      p = proto_of(u, c, s);
      for (int k = 2; k > 0; k--) begin
         exp_v[k] = exp_v[k-1]; exp_d[k] = exp_d[k-1];
         exp_e[k] = exp_e[k-1]; exp_t[k] = exp_t[k-1];
      end
      exp_v[0] = v;
      exp_d[0] = ref_vsid(p);
      exp_e[0] = (p == 36'hF_FFFF_FFFF);
      exp_t[0] = tag;
      in_valid = v; in_user = u; in_ctx = c; in_seg = s;
      @(posedge clk);
      @(negedge clk);
   endtask

   // one isolated request; checks the three-edge latency and returns the result
   task automatic single(logic u, logic [18:0] c, logic [35:0] s,
                         output logic [35:0] vs, output logic er);
      in_valid = 1'b1; in_user = u; in_ctx = c; in_seg = s;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R6 not yet valid after two edges", 64'(out_valid), 64'd0);
      @(posedge clk); @(negedge clk);
      check("R6 valid after three edges", 64'(out_valid), 64'd1);
      vs = out_vsid;
      er = out_err;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [35:0] vs;
      logic        er;
      logic [35:0] ref_a;
      clear_pipe();
      rst_n = 1'b0; in_valid = 1'b0; in_user = 1'b0; in_ctx = '0; in_seg = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R7 reset out_valid", 64'(out_valid), 64'd0);
      check("R7 reset out_err", 64'(out_err), 64'd0);
      check("R7 reset out_vsid", 64'(out_vsid), 64'd0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);

      // table walk, back to back (R1 R2 R3 R4 R5 R6)
      for (int i = 0; i < N_VEC; i++) begin
         step(1'b1, VEC[i][55], VEC[i][54:36], VEC[i][35:0],
              $sformatf("R1 table %0d", i));
      end
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0, "flush");

      // directed corners
      single(1'b0, 19'h0, 36'h0, vs, er);
      check("R4 zero maps to zero", 64'(vs), 64'd0);
      single(1'b0, 19'h0, 36'h1, vs, er);
      check("R4 one maps to multiplier", 64'(vs), 64'd200730139);
      single(1'b0, 19'h0, 36'hF_FFFF_FFFE, vs, er);
      check("R8 top proto corrected", 64'(vs), 64'd68518746596);
      check("R8 top proto no err", 64'(er), 64'd0);
      single(1'b0, 19'h0, 36'hF_FFFF_FFFF, vs, er);
      check("R5 reserved err", 64'(er), 64'd1);
      check("R5 reserved result", 64'(vs), 64'd0);
      single(1'b1, 19'h2A5A5, 36'h0_0000_3C3C, vs, er);
      ref_a = vs;
      single(1'b1, 19'h2A5A5, 36'hF_FFFF_3C3C, vs, er);
      check("R2 upper seg bits ignored", 64'(vs), 64'(ref_a));
      check("R2 user value", 64'(vs), 64'(ref_vsid({1'b0, 19'h2A5A5, 16'h3C3C})));
      single(1'b0, 19'h00000, 36'h7_1234_ABCD, vs, er);
      ref_a = vs;
      single(1'b0, 19'h7FFFF, 36'h7_1234_ABCD, vs, er);
      check("R3 ctx ignored in kernel mode", 64'(vs), 64'(ref_a));

      // random stream with bubbles (R1 R2 R3 R6)
      for (int i = 0; i < 400; i++) begin
         logic [35:0] s;
         s = {4'($urandom), 32'($urandom)};
         if (i % 97 == 5) s = 36'hF_FFFF_FFFF;
         step($urandom_range(0, 3) != 0, 1'($urandom), 19'($urandom), s,
              $sformatf("R1 random %0d", i));
      end
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0, "flush");

      // reset in flight (R7)
      step(1'b1, 1'b0, '0, 36'h0_0000_0005, "R7 pre");
      step(1'b1, 1'b0, '0, 36'hF_FFFF_FFFF, "R7 pre");
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R7 mid reset out_valid", 64'(out_valid), 64'd0);
      check("R7 mid reset out_err", 64'(out_err), 64'd0);
      rst_n = 1'b1;
      clear_pipe();
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, '0, "R7 drained");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule